// File: doc/BRIEF.md
# Per-Bit Access-Policy Register Bank

This block is a small register bank on a single-cycle bus. Software sees a few registers through an address, a write strobe with write data, and a read strobe with read data. A parameter gives every stored bit its own software-access rule. Some rules change bits on a read, some clear or set bits on a write, one locks bits after their first write, and one turns a write into an event instead of a stored change.

Hardware logic sits on the other side of the bank. It can raise status bits through a per-bit set input and observe every stored bit through a flat output vector. It also receives a one-cycle pulse for each event bit that software fires. Read data is registered, and it always carries the value from before any change that the same read causes.

Each bit's rule comes from a 4-bit code in the `POLICY` parameter. Bit `i` uses the code at `POLICY[4*i +: 4]`, where the flat index is `i = register*DATA_W + bit`. Each bit's reset value comes from `RESET_VAL[i]`.

Top module: `regbank_multi_access`

## Requirements
- R1: After reset, every stored bit (`hw_q`) equals its `RESET_VAL` bit, `trig_pulse` is all zero, and a read of any register returns its reset view.
- R2: Code 0 (plain read/write) stores the written bit on a write to its register. Code 2 (write-only) stores the written bit on `hw_q`, but a read always returns its reset value.
- R3: Code 1 (read-only) ignores writes. It takes the value of its `hw_set` input one cycle later and holds its reset value while reset is asserted.
- R4: Code 3 clears its bit when a write to its register carries 0 in that position; a written 1 leaves it unchanged. Code 4 clears when the written bit is 1; a written 0 leaves it unchanged. In both, `hw_set` high sets the bit to 1.
- R5: Code 5 clears on any write to its register, whatever the data. `hw_set` high sets it to 1.
- R6: For codes 3, 4, 5 and 6, a `hw_set` that arrives in the same cycle as a software clear wins, and the bit is 1 afterwards.
- R7: Code 6 clears after a read of its register, and code 7 sets after a read of its register. Writes have no effect on either. The read data carries the value from before that read's change.
- R8: Code 8 is set by writing 1. Writing 0 has no effect, so once set it stays 1 until reset.
- R9: Code 9 takes the written bit only on the first write to its register after reset. All later writes are ignored until the next reset.
- R10: Code 10 inverts its value when the written bit is 1 and holds when the written bit is 0.
- R11: Code 11 raises its `trig_pulse` bit for exactly the cycle after a write with a 1 in its position. Its stored and read value stays at its reset value.
- R12: Code 12 (reserved) and codes 13 to 15 keep their reset value and ignore writes and reads.
- R13: `rd_data` updates on the clock edge that samples `rd_en` and holds otherwise. In the default configuration, bit `i` uses code `i mod 13`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register select for the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | DATA_W | Registered read data |
| hw_set | input | 2**ADDR_W*DATA_W | Per-bit hardware set / status input |
| hw_q | output | 2**ADDR_W*DATA_W | All stored bits, flat index register*DATA_W+bit |
| trig_pulse | output | 2**ADDR_W*DATA_W | One-cycle event pulses for write-1-trigger bits |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that `rst` is high from time zero until the first clock edges have passed. The stimulus keeps to both: each cycle chooses exactly one of write, read or idle, and the first reset lasts two edges. Under these limits the assertions check the same-cycle hardware-set priority, toggling, lock hold, read-side set and clear, and pulse gating. The random `hw_set` values are kept sparse so that software clears remain visible often enough to check. Directed bursts of all-ones and all-zeros writes, issued while `hw_set` is held high, force the priority cases.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [3:0] {
    POL_RW     = 4'd0,
    POL_RO     = 4'd1,
    POL_WO     = 4'd2,
    POL_CLR_W0 = 4'd3,
    POL_CLR_W1 = 4'd4,
    POL_CLR_WR = 4'd5,
    POL_CLR_RD = 4'd6,
    POL_SET_RD = 4'd7,
    POL_SET    = 4'd8,
    POL_ONCE   = 4'd9,
    POL_TOGGLE = 4'd10,
    POL_TRIG   = 4'd11,
    POL_RSVD   = 4'd12
  } pol_e;

  localparam int DEF_BITS = 32;

  // Default configuration: flat bit i uses code (i mod 13).
  function automatic logic [4*DEF_BITS-1:0] default_policy();
    logic [4*DEF_BITS-1:0] v;
    v = '0;
    for (int i = 0; i < DEF_BITS; i++) begin
      v[4*i +: 4] = 4'(i % 13);
    end
    return v;
  endfunction

endpackage

// File: rtl/regbank_bit_cell.sv
module regbank_bit_cell
  import regbank_pkg::*;
#(
  parameter pol_e POL = POL_RW,
  parameter logic RST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic rd_hit,
  input  logic wr_bit,
  input  logic hw_set,
  input  logic locked,
  output logic q,
  output logic trig
);

  logic q_nxt;
  logic trig_nxt;

  always_comb begin
    q_nxt    = q;
    trig_nxt = 1'b0;
    case (POL)
      POL_RW, POL_WO: if (wr_hit) q_nxt = wr_bit;
      POL_RO:         q_nxt = hw_set;
      POL_CLR_W0: begin
        if (wr_hit && !wr_bit) q_nxt = 1'b0;
        if (hw_set) q_nxt = 1'b1;
      end
      POL_CLR_W1: begin
        if (wr_hit && wr_bit) q_nxt = 1'b0;
        if (hw_set) q_nxt = 1'b1;
      end
      POL_CLR_WR: begin
        if (wr_hit) q_nxt = 1'b0;
        if (hw_set) q_nxt = 1'b1;
      end
      POL_CLR_RD: begin
        if (rd_hit) q_nxt = 1'b0;
        if (hw_set) q_nxt = 1'b1;
      end
      POL_SET_RD: if (rd_hit) q_nxt = 1'b1;
      POL_SET:    if (wr_hit && wr_bit) q_nxt = 1'b1;
      POL_ONCE:   if (wr_hit && !locked) q_nxt = wr_bit;
      POL_TOGGLE: if (wr_hit && wr_bit) q_nxt = ~q;
      POL_TRIG:   trig_nxt = wr_hit && wr_bit;
      default:    q_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= RST;
      trig <= 1'b0;
    end else begin
      q    <= q_nxt;
      trig <= trig_nxt;
    end
  end

  generate
    if (POL == POL_CLR_W0 || POL == POL_CLR_W1 || POL == POL_CLR_WR || POL == POL_CLR_RD) begin : g_a_status
      a_r6_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
        hw_set |=> q);
    end
    if (POL == POL_CLR_RD) begin : g_a_clr_rd
      a_r7_clear_after_read: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !hw_set) |=> !q);
    end
    if (POL == POL_SET_RD) begin : g_a_set_rd
      a_r7_set_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> q);
    end
    if (POL == POL_SET) begin : g_a_set
      a_r8_set_sticky: assert property (@(posedge clk) disable iff (rst)
        q |=> q);
    end
    if (POL == POL_ONCE) begin : g_a_once
      a_r9_locked_hold: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(q));
    end
    if (POL == POL_TOGGLE) begin : g_a_tog
      a_r10_flip: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wr_bit) |=> (q != $past(q)));
    end
    if (POL == POL_TRIG) begin : g_a_trig
      a_r11_no_pulse_without_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit && wr_bit) |=> !trig);
    end
  endgenerate

endmodule

// File: rtl/regbank_wonce_lock.sv
module regbank_wonce_lock #(
  parameter int NUM_REGS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] wr_hit,
  output logic [NUM_REGS-1:0] locked
);

  always_ff @(posedge clk) begin
    if (rst) locked <= '0;
    else     locked <= locked | wr_hit;
  end

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (|locked) |=> ((locked & $past(locked)) == $past(locked)));

  a_r9_lock_on_write: assert property (@(posedge clk) disable iff (rst)
    (|wr_hit) |=> (|locked));

endmodule

// File: rtl/regbank_rd_port.sv
module regbank_rd_port #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  localparam int NUM_REGS = 2 ** ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_REGS*DATA_W-1:0] view,
  output logic [DATA_W-1:0]          rd_data
);

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= view[addr*DATA_W +: DATA_W];
  end

  a_r13_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/regbank_multi_access.sv
module regbank_multi_access
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [4*(2**ADDR_W)*DATA_W-1:0] POLICY    = regbank_pkg::default_policy(),
  parameter logic [(2**ADDR_W)*DATA_W-1:0]   RESET_VAL = 32'h9C5A_36E1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             wr_en,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             rd_en,
  output logic [DATA_W-1:0]                rd_data,
  input  logic [(2**ADDR_W)*DATA_W-1:0]    hw_set,
  output logic [(2**ADDR_W)*DATA_W-1:0]    hw_q,
  output logic [(2**ADDR_W)*DATA_W-1:0]    trig_pulse
);

  localparam int NUM_REGS = 2 ** ADDR_W;
  localparam int NUM_BITS = NUM_REGS * DATA_W;

  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_REGS-1:0] rd_hit;
  logic [NUM_REGS-1:0] locked;
  logic [NUM_BITS-1:0] view;

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      assign wr_hit[r] = wr_en && (addr == ADDR_W'(r));
      assign rd_hit[r] = rd_en && (addr == ADDR_W'(r));

      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        localparam int   IDX = r * DATA_W + b;
        localparam pol_e P   = pol_e'(POLICY[4*IDX +: 4]);

        regbank_bit_cell #(
          .POL (P),
          .RST (RESET_VAL[IDX])
        ) u_cell (
          .clk    (clk),
          .rst    (rst),
          .wr_hit (wr_hit[r]),
          .rd_hit (rd_hit[r]),
          .wr_bit (wr_data[b]),
          .hw_set (hw_set[IDX]),
          .locked (locked[r]),
          .q      (hw_q[IDX]),
          .trig   (trig_pulse[IDX])
        );

        if (P == POL_WO) begin : g_mask
          assign view[IDX] = RESET_VAL[IDX];
        end else begin : g_pass
          assign view[IDX] = hw_q[IDX];
        end
      end
    end
  endgenerate

  regbank_wonce_lock #(
    .NUM_REGS (NUM_REGS)
  ) u_lock (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (wr_hit),
    .locked (locked)
  );

  regbank_rd_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .view    (view),
    .rd_data (rd_data)
  );

  a_r13_access_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

endmodule

// File: tb/regbank_multi_access_bench.sv
module regbank_multi_access_bench;
  import regbank_pkg::*;

  localparam int AW = 2;
  localparam int DW = 8;
  localparam int NR = 4;
  localparam int NB = NR * DW;
  localparam logic [4*NB-1:0] POLV = default_policy();
  localparam logic [NB-1:0]   RSTV = 32'h9C5A_36E1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic [NB-1:0] hw_set = '0;
  logic [NB-1:0] hw_q;
  logic [NB-1:0] trig_pulse;

  logic [NB-1:0] mq;
  logic [NR-1:0] mlock;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regbank_multi_access #(
    .ADDR_W    (AW),
    .DATA_W    (DW),
    .POLICY    (POLV),
    .RESET_VAL (RSTV)
  ) u_regbank_multi_access (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .hw_set     (hw_set),
    .hw_q       (hw_q),
    .trig_pulse (trig_pulse)
  );

  function automatic int pol_of(int i);
    return i % 13;
  endfunction

  function automatic logic next_bit(int p, logic q, logic rs, logic wr, logic rd,
                                    logic wd, logic hs, logic lk);
    logic n;
    n = q;
    case (p)
      0, 2: if (wr) n = wd;
      1:  n = hs;
      3:  begin if (wr && !wd) n = 1'b0; if (hs) n = 1'b1; end
      4:  begin if (wr && wd) n = 1'b0; if (hs) n = 1'b1; end
      5:  begin if (wr) n = 1'b0; if (hs) n = 1'b1; end
      6:  begin if (rd) n = 1'b0; if (hs) n = 1'b1; end
      7:  if (rd) n = 1'b1;
      8:  if (wr && wd) n = 1'b1;
      9:  if (wr && !lk) n = wd;
      10: if (wr && wd) n = ~q;
      default: n = rs;
    endcase
    return n;
  endfunction

  function automatic string tag_of(int p, logic hs);
    if ((p >= 3 && p <= 6) && hs) return "R6";
    case (p)
      0, 2:  return "R2";
      1:     return "R3";
      3, 4:  return "R4";
      5:     return "R5";
      6, 7:  return "R7";
      8:     return "R8";
      9:     return "R9";
      10:    return "R10";
      11:    return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(bit we, bit re, logic [AW-1:0] a, logic [DW-1:0] wd, logic [NB-1:0] hs);
    logic [DW-1:0] exp_rd;
    logic [NB-1:0] exp_trig;
    logic [NB-1:0] nq;
    addr = a; wr_en = we; rd_en = re; wr_data = wd; hw_set = hs;
    for (int b = 0; b < DW; b++) begin
      int i;
      i = int'(a) * DW + b;
      exp_rd[b] = (pol_of(i) == 2) ? RSTV[i] : mq[i];
    end
    for (int i = 0; i < NB; i++) begin
      int r;
      r = i / DW;
      nq[i] = next_bit(pol_of(i), mq[i], RSTV[i], we && (r == int'(a)),
                       re && (r == int'(a)), wd[i % DW], hs[i], mlock[r]);
      exp_trig[i] = (pol_of(i) == 11) && we && (r == int'(a)) && wd[i % DW];
    end
    @(posedge clk);
    #1;
    mq = nq;
    if (we) mlock[a] = 1'b1;
    for (int i = 0; i < NB; i++) begin
      check(tag_of(pol_of(i), hs[i]), $sformatf("hw_q[%0d]", i), hw_q[i], mq[i]);
      check("R11", $sformatf("trig_pulse[%0d]", i), trig_pulse[i], exp_trig[i]);
    end
    if (re) begin
      for (int b = 0; b < DW; b++) begin
        check((pol_of(int'(a) * DW + b) == 2) ? "R2" : "R13",
              $sformatf("rd_data[%0d] reg %0d", b, a), rd_data[b], exp_rd[b]);
      end
    end
  endtask

  task automatic do_reset();
    wr_en = 1'b0; rd_en = 1'b0; hw_set = '0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    mq = RSTV;
    mlock = '0;
    for (int i = 0; i < NB; i++) begin
      check("R1", $sformatf("reset hw_q[%0d]", i), hw_q[i], RSTV[i]);
      check("R1", $sformatf("reset trig[%0d]", i), trig_pulse[i], 1'b0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1: reset view read back through the bus
    for (int r = 0; r < NR; r++) step(0, 1, AW'(r), '0, '0);
    // R9: first writes lock; R2/R4/R8/R10/R11 with all ones
    for (int r = 0; r < NR; r++) step(1, 0, AW'(r), 8'hFF, '0);
    for (int r = 0; r < NR; r++) step(1, 0, AW'(r), 8'h00, '0);
    // R7: double reads expose pre-side-effect value
    for (int r = 0; r < NR; r++) begin
      step(0, 1, AW'(r), '0, '0);
      step(0, 1, AW'(r), '0, '0);
    end
    // R6: hardware set collides with software clears
    for (int r = 0; r < NR; r++) begin
      step(1, 0, AW'(r), 8'hFF, '1);
      step(1, 0, AW'(r), 8'h00, '1);
      step(0, 1, AW'(r), 8'h00, '1);
    end
    // R11: back-to-back trigger writes
    step(1, 0, 2'd3, 8'h01, '0);
    step(1, 0, 2'd3, 8'h01, '0);
    step(0, 0, 2'd3, 8'h00, '0);
    // Constrained random traffic
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom % 5);
      step(op < 2, op >= 2 && op < 4, AW'($urandom), DW'($urandom),
           NB'($urandom & $urandom & $urandom));
    end
    // R9: reset unlocks write-once bits
    do_reset();
    step(1, 0, 2'd1, 8'h02, '0);
    step(1, 0, 2'd1, 8'h00, '0);
    step(1, 0, 2'd2, 8'h40, '0);
    step(1, 0, 2'd2, 8'h00, '0);
    step(0, 1, 2'd1, 8'h00, '0);
    step(0, 1, 2'd2, 8'h00, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule